// File: doc/BRIEF.md
# Step-Attenuator Serial Control Master

This block lets on-chip logic set a 6-bit digital step attenuator through a three-wire serial link made of a shift clock, a data line and a latch strobe. A requester presents an attenuation in half-decibel units (0 to 63) together with a one-cycle start. Values above 63 are clamped to 63. The block turns the value into the attenuator's active-low control word and shifts it out, most significant bit first. It then strobes the latch line and raises a one-cycle completion pulse.

Every interval on the link is a whole number of system-clock cycles set by parameters: the clock low phase, the clock high phase, the gap between the final falling clock and the latch strobe, and the strobe width. The defaults give 30 ns phases, a 10 ns gap and a 30 ns strobe at a 100 MHz system clock. Data changes only while the link clock is low and is sampled by the attenuator on the rising edge.

The controller is a state machine with six states. **IDLE** waits for a start. **SHIFT_LO** drives the clock low with the current bit. **SHIFT_HI** drives it high. **GAP** holds the link quiet before the strobe. **STROBE** holds the latch line high. **FINISH** produces the completion pulse. The transitions are: IDLE→SHIFT_LO on an accepted start; SHIFT_LO→SHIFT_HI when the low phase expires; SHIFT_HI→SHIFT_LO when the high phase expires and bits remain; SHIFT_HI→GAP after the last bit's high phase; GAP→STROBE when the gap expires; STROBE→FINISH when the strobe width expires; FINISH→IDLE always. The pins are registered, so they show each state one cycle after the state register enters it. `busy_o` follows the state register directly.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is held and right after it is released, `sclk_o`, `sdata_o`, `sle_o`, `done_o` and `busy_o` are all low.
- R2: The word sent is the bitwise inverse of the requested attenuation in 0.5 dB units. A request of 0 sends 111111, a request of 63 sends 000000, and in general a request of n sends 63 − n.
- R3: A request above 63 is clamped to 63 before encoding, so it sends 000000.
- R4: Each frame holds exactly six bits, sent most significant first. Each bit sits on `sdata_o` for LOW_CYC cycles with `sclk_o` low, then for HIGH_CYC cycles with `sclk_o` high. `sdata_o` never changes while `sclk_o` is high, and `sclk_o` idles low.
- R5: After the sixth falling clock, `sle_o` stays low for SETUP_CYC cycles and then goes high for exactly WIDTH_CYC cycles. `sle_o` and `sclk_o` are never high together, and `sdata_o` is low during the gap and the strobe.
- R6: `done_o` is high for exactly one cycle, in the cycle right after `sle_o` falls.
- R7: `busy_o` rises in the cycle after the edge that accepts a start. It stays high until it falls in the cycle where `done_o` is high. A start sampled while `busy_o` is high has no effect on the pins.
- R8: A start sampled at the edge that ends the `done_o` cycle is accepted. With `start_i` held high, frames follow one another with `busy_o` low only in each `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new frame; sampled at the rising edge |
| atten_i | input | REQ_W | Requested attenuation in 0.5 dB units, captured with the start |
| busy_o | output | 1 | Frame in progress; starts are ignored while high |
| done_o | output | 1 | One-cycle completion pulse after the latch strobe |
| sclk_o | output | 1 | Serial link clock, idles low |
| sdata_o | output | 1 | Serial link data, most significant bit first |
| sle_o | output | 1 | Latch strobe, idles low |

## Verification
Two things can meet in one cycle: the completion pulse of one frame and the acceptance of the next start. Because `busy_o` is already low while `done_o` is high, a start sampled at the edge that ends that cycle begins a new frame. A start sampled one cycle earlier, while the state machine is still finishing, is dropped. The bench provokes both cases. It raises `start_i` exactly when it sees `done_o`, and it also holds `start_i` high across several frames. A behavioural model built from queues predicts all five outputs on every clock. Each frame's bits are also collected at the rising link clock and checked against the expected inverted code when the strobe rises.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    // Controller states; the names match the state descriptions in the brief.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SHIFT_LO = 3'd1,
        ST_SHIFT_HI = 3'd2,
        ST_GAP      = 3'd3,
        ST_STROBE   = 3'd4,
        ST_FINISH   = 3'd5
    } ser_state_e;

    // Largest of the four timing parameters; sizes the shared phase timer.
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/atten_code_enc.sv
// Clamps the request to the code range, then inverts it (all ones = 0 dB).
module atten_code_enc #(
    parameter int REQ_W  = 8,
    parameter int CODE_W = 6
) (
    input  logic [REQ_W-1:0]  req_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] clamped;

    generate
        if (REQ_W > CODE_W) begin : g_clamp
            logic over;
            assign over    = |req_i[REQ_W-1:CODE_W];
            assign clamped = over ? {CODE_W{1'b1}} : req_i[CODE_W-1:0];
        end else if (REQ_W == CODE_W) begin : g_pass
            assign clamped = req_i;
        end else begin : g_widen
            assign clamped = {{(CODE_W-REQ_W){1'b0}}, req_i};
        end
    endgenerate

    assign code_o = ~clamped;

endmodule

// File: rtl/atten_phase_timer.sv
// Down counter shared by all timed states; it is reloaded on every state change.
module atten_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/atten_shift_out.sv
// Holds the frame word, presents its top bit and counts the bits sent.
module atten_shift_out #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              last_o
);

    localparam int IDX_W = (CODE_W > 2) ? $clog2(CODE_W) : 1;

    logic [CODE_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
            idx_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[CODE_W-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign msb_o  = sreg_q[CODE_W-1];
    assign last_o = (idx_q == IDX_W'(CODE_W - 1));

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
    import atten_ser_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int REQ_W     = 8,
    parameter int LOW_CYC   = 3,
    parameter int HIGH_CYC  = 3,
    parameter int SETUP_CYC = 1,
    parameter int WIDTH_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REQ_W-1:0] atten_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             sle_o
);

    localparam int MAX_CYC = max_of4(LOW_CYC, HIGH_CYC, SETUP_CYC, WIDTH_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;

    ser_state_e        state_q, state_nx;
    logic [CODE_W-1:0] code;
    logic              accept;
    logic              expired;
    logic              last_bit;
    logic              msb;
    logic              shift;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;

    logic sclk_q, sdata_q, sle_q, done_q;

    atten_code_enc #(
        .REQ_W  (REQ_W),
        .CODE_W (CODE_W)
    ) u_enc (
        .req_i  (atten_i),
        .code_o (code)
    );

    atten_phase_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (expired)
    );

    atten_shift_out #(
        .CODE_W (CODE_W)
    ) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .word_i  (code),
        .shift_i (shift),
        .msb_o   (msb),
        .last_o  (last_bit)
    );

    assign accept = (state_q == ST_IDLE) && start_i;
    assign shift  = (state_q == ST_SHIFT_HI) && expired && !last_bit;

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_nx = ST_SHIFT_LO;
            ST_SHIFT_LO: if (expired) state_nx = ST_SHIFT_HI;
            ST_SHIFT_HI: if (expired) state_nx = last_bit ? ST_GAP : ST_SHIFT_LO;
            ST_GAP:      if (expired) state_nx = ST_STROBE;
            ST_STROBE:   if (expired) state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // The timer is reloaded with the length of the state being entered.
    always_comb begin
        tmr_load = (state_nx != state_q);
        unique case (state_nx)
            ST_SHIFT_LO: tmr_val = CNT_W'(LOW_CYC - 1);
            ST_SHIFT_HI: tmr_val = CNT_W'(HIGH_CYC - 1);
            ST_GAP:      tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_STROBE:   tmr_val = CNT_W'(WIDTH_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Output register: the pins follow the state one cycle later, free of glitches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sdata_q <= 1'b0;
            sle_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            sclk_q  <= (state_q == ST_SHIFT_HI);
            sdata_q <= ((state_q == ST_SHIFT_LO) || (state_q == ST_SHIFT_HI)) && msb;
            sle_q   <= (state_q == ST_STROBE);
            done_q  <= (state_q == ST_FINISH);
        end
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign sclk_o  = sclk_q;
    assign sdata_o = sdata_q;
    assign sle_o   = sle_q;
    assign done_o  = done_q;

endmodule

// File: rtl/atten_serial_master_chk.sv
module atten_serial_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic sclk_o,
    input logic sdata_o,
    input logic sle_o
);

    AST_DATA_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R4

    AST_STROBE_CLK_APART: assert property (@(posedge clk) disable iff (!rst_n)
        sle_o |-> !sclk_o); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sle_o)); // R6

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R7

    AST_IDLE_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !sle_o && !sdata_o)); // R7

endmodule

bind atten_serial_master atten_serial_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .sle_o   (sle_o)
);

// File: tb/atten_serial_master_bench.sv
`timescale 1ns/1ps
module atten_serial_master_bench;

    localparam int L_C = 2;
    localparam int H_C = 3;
    localparam int S_C = 2;
    localparam int W_C = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] atten_i = 8'd0;
    logic       busy_o, done_o, sclk_o, sdata_o, sle_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    atten_serial_master #(
        .CODE_W(6), .REQ_W(8), .LOW_CYC(L_C), .HIGH_CYC(H_C),
        .SETUP_CYC(S_C), .WIDTH_CYC(W_C)
    ) u_atten_serial_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .atten_i(atten_i),
        .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .sle_o(sle_o)
    );

    // Reference model: expected {busy, sclk, sdata, sle, done} for each cycle.
    logic [4:0] exp_q[$];
    logic [4:0] exp_now = 5'b0;
    int         code_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q.delete();
            code_q.delete();
            exp_now = 5'b0;
        end else begin
            if (exp_q.size() == 0 && start_i) begin
                int a;
                int code;
                a = int'(atten_i);
                code = 63 - ((a > 63) ? 63 : a);
                code_q.push_back(code | ((a > 63) ? 256 : 0));
                exp_q.push_back(5'b10000);
                for (int b = 5; b >= 0; b--) begin
                    logic bv;
                    bv = ((code >> b) & 1) != 0;
                    for (int k = 0; k < L_C; k++) exp_q.push_back({1'b1, 1'b0, bv, 1'b0, 1'b0});
                    for (int k = 0; k < H_C; k++) exp_q.push_back({1'b1, 1'b1, bv, 1'b0, 1'b0});
                end
                for (int k = 0; k < S_C; k++) exp_q.push_back(5'b10000);
                for (int k = 0; k < W_C; k++) exp_q.push_back(5'b10010);
                exp_q.push_back(5'b00001);
            end
            exp_now = (exp_q.size() != 0) ? exp_q.pop_front() : 5'b0;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", rq, what, cyc, act, expv);
        end
    endtask

    // Every-cycle comparison plus decoding of each frame's word at the strobe.
    logic       prev_sclk = 1'b0;
    logic       prev_sle = 1'b0;
    logic [5:0] cap = 6'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            chk(busy_o  == exp_now[4], "R7", "busy",  int'(busy_o),  int'(exp_now[4]));
            chk(sclk_o  == exp_now[3], "R4", "sclk",  int'(sclk_o),  int'(exp_now[3]));
            chk(sdata_o == exp_now[2], "R4", "sdata", int'(sdata_o), int'(exp_now[2]));
            chk(sle_o   == exp_now[1], "R5", "sle",   int'(sle_o),   int'(exp_now[1]));
            chk(done_o  == exp_now[0], "R6", "done",  int'(done_o),  int'(exp_now[0]));
            if (sclk_o && !prev_sclk) cap = {cap[4:0], sdata_o};
            if (sle_o && !prev_sle) begin
                int e;
                e = (code_q.size() != 0) ? code_q.pop_front() : -1;
                if (e >= 256) chk(int'(cap) == (e & 63), "R3", "clamped word", int'(cap), e & 63);
                else          chk(int'(cap) == e,        "R2", "sent word",    int'(cap), e);
            end
            prev_sclk = sclk_o;
            prev_sle  = sle_o;
        end
    end

    task automatic send(input int a);
        @(negedge clk);
        atten_i = 8'(a);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R7 watchdog: actual still running, expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet while reset is held
        chk({busy_o, sclk_o, sdata_o, sle_o, done_o} == 5'b0, "R1", "reset outputs",
            int'({busy_o, sclk_o, sdata_o, sle_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, sclk_o, sdata_o, sle_o, done_o} == 5'b0, "R1", "after reset",
            int'({busy_o, sclk_o, sdata_o, sle_o, done_o}), 0);

        // R2: minimum, maximum and mixed codes
        send(0);   wait_idle();
        send(63);  wait_idle();
        send(1);   wait_idle();
        send(42);  wait_idle();
        send(21);  wait_idle();
        send(32);  wait_idle();
        // R3: clamping of oversized requests
        send(64);  wait_idle();
        send(100); wait_idle();
        send(255); wait_idle();

        // R7: a start in the middle of a frame is ignored
        send(5);
        repeat (10) @(negedge clk);
        atten_i = 8'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        // R8: start raised exactly in the done cycle is accepted
        send(12);
        @(negedge clk);
        while (!done_o) @(negedge clk);
        atten_i = 8'd50; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8", "start in done cycle", int'(busy_o), 1);
        wait_idle();

        // R8: start held high gives back-to-back frames
        atten_i = 8'd7; start_i = 1'b1;
        repeat (100) @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        summary();
        $finish;
    end

endmodule